// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits in the read path of a nonvolatile memory array. While the array is busy with an internal programming period, a read does not show plain array contents. Instead it carries two independent end-of-write indications. The top data bit is a polling bit: it holds the inverse of the top bit of the byte most recently written. The bit below it is a toggle bit, and its value flips once for every new read access. When the programming period ends, reads return the array data unchanged and the toggle bit stops moving.

A host can use either indication, starting at any point in the programming period. A read access begins when the read strobe rises. While the strobe stays high, the block keeps refreshing the returned byte, but the toggle bit does not advance again. The toggle state is cleared when a new programming period starts, so the first read of each period returns 1 in the toggle position. A parameter chooses where the polling bit appears. In the default setting it appears only when the read address equals the last written address. In the other setting it appears at every address.

Top module: `wr_status_rdmux`

## Requirements
- R1: While reset is active and after its release, `rd_data` is all zeros until the first read.
- R2: `rd_data` is registered. It takes a new value one clock after each cycle in which `rd_strobe` is high, and holds its value in any cycle in which `rd_strobe` is low.
- R3: While `busy` is low, a read returns `arr_rdata` on all bits, including both status positions.
- R4: While `busy` is high, bit DW-1 of a read is the inverse of bit DW-1 of `wr_last_data`, provided that `rd_addr` equals `wr_last_addr` or POLL_ANY_ADDR is 1.
- R5: While `busy` is high, bit DW-2 of a read holds the toggle state. That state inverts once on each rising edge of `rd_strobe`, and a strobe held high for several cycles does not invert it again.
- R6: A rising edge of `busy` clears the toggle state. The first read of a period therefore returns 1 at bit DW-2, and this also holds when that read starts in the same cycle as `busy` rises.
- R7: While `busy` is high, bits DW-3 down to 0 of a read come from `arr_rdata`.
- R8: When POLL_ANY_ADDR is 0, a read during `busy` at an address other than `wr_last_addr` returns `arr_rdata` bit DW-1 in bit DW-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_strobe | input | 1 | Read access. High while a read is in progress; a rising edge starts a new access |
| rd_addr | input | AW | Address being read |
| arr_rdata | input | DW | Array contents at `rd_addr` |
| busy | input | 1 | High while a programming period runs |
| wr_last_data | input | DW | Last byte loaded for programming |
| wr_last_addr | input | AW | Address of that last byte |
| rd_data | output | DW | Returned read byte |

## Verification
If the toggle state goes wrong, the error shows at the first read of a busy period, or at the first read after a held strobe. The toggle bit then returns the same value twice, or returns 0 where 1 is expected right after a period starts. A wrong source selection shows within one clock of the affected read. In that case the polling bit, the toggle bit or the low bits differ from the value that the inputs of that cycle fix. A missing restart is made visible by ending a period with the toggle at 1, so the next period's first read would return 0 instead of 1.

// File: rtl/wsr_pkg.sv
// Shared types for the write completion status reporter.
// Assumes: nothing beyond IEEE 1800-2017.
package wsr_pkg;
    // Source that feeds the status positions of a read
    typedef enum logic {
        SRC_ARRAY  = 1'b0,
        SRC_STATUS = 1'b1
    } src_e;
endpackage

// File: rtl/wsr_edge.sv
// Rising-edge detector for a single-bit level.
// Assumes: sig_i is synchronous to clk.
module wsr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic sig_q;

    // Remember last cycle's level
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/wsr_toggle.sv
// Toggle-bit state: cleared when a period restarts, inverted on each advance.
// Assumes: restart and advance are single-cycle pulses.
module wsr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic advance_i,
    output logic tgl_next_o
);
    logic tgl_q;

    // Next value: restart wins over the old state; the advance still applies
    always_comb begin
        if (restart_i) tgl_next_o = advance_i;
        else           tgl_next_o = tgl_q ^ advance_i;
    end

    // Hold the toggle state
    always_ff @(posedge clk) begin
        if (!rst_n) tgl_q <= 1'b0;
        else        tgl_q <= tgl_next_o;
    end
endmodule

// File: rtl/wsr_compose.sv
// Builds the read byte: array data when idle, status bits overlaid when busy.
// Assumes: DW >= 3; the polling bit is DW-1 and the toggle bit is DW-2.
module wsr_compose #(
    parameter int DW            = 8,
    parameter int AW            = 13,
    parameter bit POLL_ANY_ADDR = 1'b0
) (
    input  logic          busy_i,
    input  logic          tgl_i,
    input  logic [AW-1:0] rd_addr_i,
    input  logic [AW-1:0] wr_last_addr_i,
    input  logic [DW-1:0] wr_last_data_i,
    input  logic [DW-1:0] arr_rdata_i,
    output logic [DW-1:0] data_o
);
    import wsr_pkg::*;

    localparam int POLL_BIT = DW - 1;
    localparam int TGL_BIT  = DW - 2;

    logic poll_hit;
    src_e src;

    // Select where the polling bit is presented
    generate
        if (POLL_ANY_ADDR) begin : g_any
            assign poll_hit = 1'b1;
        end else begin : g_match
            assign poll_hit = (rd_addr_i == wr_last_addr_i);
        end
    endgenerate

    // Overlay the status bits onto the array byte
    always_comb begin
        src    = busy_i ? SRC_STATUS : SRC_ARRAY;
        data_o = arr_rdata_i;
        if (src == SRC_STATUS) begin
            data_o[TGL_BIT] = tgl_i;
            if (poll_hit) data_o[POLL_BIT] = ~wr_last_data_i[POLL_BIT];
        end
    end
endmodule

// File: rtl/wr_status_rdmux.sv
// Read-path multiplexer that reports end-of-write status while busy.
// Assumes: all inputs synchronous to clk; arr_rdata is valid for rd_addr
// in the same cycle; a read access starts on a rising edge of rd_strobe.
module wr_status_rdmux #(
    parameter int DW            = 8,
    parameter int AW            = 13,
    parameter bit POLL_ANY_ADDR = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_strobe,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] arr_rdata,
    input  logic          busy,
    input  logic [DW-1:0] wr_last_data,
    input  logic [AW-1:0] wr_last_addr,
    output logic [DW-1:0] rd_data
);
    logic          rd_rise;
    logic          busy_rise;
    logic          tgl_next;
    logic [DW-1:0] composed;

    wsr_edge u_rd_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (rd_strobe),
        .rise_o (rd_rise)
    );

    wsr_edge u_busy_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (busy),
        .rise_o (busy_rise)
    );

    wsr_toggle u_toggle (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (busy_rise),
        .advance_i  (rd_rise & busy),
        .tgl_next_o (tgl_next)
    );

    wsr_compose #(
        .DW            (DW),
        .AW            (AW),
        .POLL_ANY_ADDR (POLL_ANY_ADDR)
    ) u_compose (
        .busy_i         (busy),
        .tgl_i          (tgl_next),
        .rd_addr_i      (rd_addr),
        .wr_last_addr_i (wr_last_addr),
        .wr_last_data_i (wr_last_data),
        .arr_rdata_i    (arr_rdata),
        .data_o         (composed)
    );

    // Register the returned byte during a read, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_data <= '0;
        else if (rd_strobe) rd_data <= composed;
    end
endmodule

// File: rtl/wsr_checker.sv
// Port-level properties of the write completion status reporter.
// Assumes: bound to every wr_status_rdmux instance.
module wsr_checker #(
    parameter int DW            = 8,
    parameter int AW            = 13,
    parameter bit POLL_ANY_ADDR = 1'b0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_strobe,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] arr_rdata,
    input logic          busy,
    input logic [DW-1:0] wr_last_data,
    input logic [AW-1:0] wr_last_addr,
    input logic [DW-1:0] rd_data
);
    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(rd_data));

    // R3
    idle_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rd_strobe) |=> (rd_data == $past(arr_rdata)));

    // R4
    poll_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_strobe && (POLL_ANY_ADDR || rd_addr == wr_last_addr))
        |=> (rd_data[DW-1] == ~$past(wr_last_data[DW-1])));

    // R5
    held_no_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_strobe && $past(busy) && $past(rd_strobe))
        |=> $stable(rd_data[DW-2]));

    // R7
    low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_strobe) |=> (rd_data[DW-3:0] == $past(arr_rdata[DW-3:0])));
endmodule

bind wr_status_rdmux wsr_checker #(
    .DW            (DW),
    .AW            (AW),
    .POLL_ANY_ADDR (POLL_ANY_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_strobe    (rd_strobe),
    .rd_addr      (rd_addr),
    .arr_rdata    (arr_rdata),
    .busy         (busy),
    .wr_last_data (wr_last_data),
    .wr_last_addr (wr_last_addr),
    .rd_data      (rd_data)
);

// File: tb/wr_status_rdmux_tb.sv
module wr_status_rdmux_tb;
    localparam int DW = 8;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_strobe = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] arr_rdata = '0;
    logic          busy = 1'b0;
    logic [DW-1:0] wr_last_data = '0;
    logic [AW-1:0] wr_last_addr = '0;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] rd_data_any;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  exp_tgl = 1'b0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    // Default variant: polling bit only at the last written address
    wr_status_rdmux #(.DW(DW), .AW(AW), .POLL_ANY_ADDR(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
        .arr_rdata(arr_rdata), .busy(busy), .wr_last_data(wr_last_data),
        .wr_last_addr(wr_last_addr), .rd_data(rd_data));

    // Variant: polling bit at every address
    wr_status_rdmux #(.DW(DW), .AW(AW), .POLL_ANY_ADDR(1'b1)) u_dut_any (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
        .arr_rdata(arr_rdata), .busy(busy), .wr_last_data(wr_last_data),
        .wr_last_addr(wr_last_addr), .rd_data(rd_data_any));

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // Expected bytes for both variants, from the requirements
    function automatic logic [DW-1:0] exp_byte(input bit any_addr);
        logic [DW-1:0] e;
        e = arr_rdata;
        if (busy) begin
            e[DW-2] = exp_tgl;                                // R5 R6
            if (any_addr || rd_addr == wr_last_addr)
                e[DW-1] = ~wr_last_data[DW-1];                // R4
        end
        return e;
    endfunction

    // One read access: strobe up, check, optionally hold, strobe down
    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input int hold, input string req);
        @(negedge clk);
        rd_addr = a; arr_rdata = d; rd_strobe = 1'b1;
        @(negedge clk);
        if (busy) exp_tgl = ~exp_tgl;
        check(req, rd_data, exp_byte(1'b0));
        check(req, rd_data_any, exp_byte(1'b1));
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check("R5 held", rd_data, exp_byte(1'b0));
            check("R5 held", rd_data_any, exp_byte(1'b1));
        end
        rd_strobe = 1'b0;
    endtask

    task automatic start_period(input logic [DW-1:0] wd, input logic [AW-1:0] wa);
        @(negedge clk);
        busy = 1'b1; wr_last_data = wd; wr_last_addr = wa; exp_tgl = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", rd_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", rd_data, '0);

        // R3: idle sweep over every byte value, toggle position included
        for (int v = 0; v < 256; v++)
            do_read(AW'(v * 7), DW'(v), 0, "R3 idle");

        // R2: no strobe, changing inputs leave rd_data unchanged
        begin
            logic [DW-1:0] held;
            @(negedge clk);
            held = rd_data;
            arr_rdata = 8'h3C; busy = 1'b0;
            repeat (3) @(negedge clk);
            check("R2 hold", rd_data, held);
        end

        // Busy period one: polling, toggling, low bits, address match
        start_period(8'h80, 13'h0155);
        for (int k = 0; k < 64; k++) begin
            logic [AW-1:0] a;
            a = (k % 2 == 0) ? 13'h0155 : AW'(k * 3 + 1);
            wr_last_data = DW'(k * 29 + 3);
            do_read(a, DW'(k * 53 + 7), 0, "R4 R7 R8 busy sweep");
        end
        // R2: no strobe while busy, inputs change, output holds
        begin
            logic [DW-1:0] held;
            @(negedge clk);
            held = rd_data;
            arr_rdata = ~arr_rdata; wr_last_data = ~wr_last_data;
            repeat (2) @(negedge clk);
            check("R2 hold busy", rd_data, held);
        end
        // R5: held strobe does not toggle again (tgl becomes 1 here)
        do_read(13'h0155, 8'hA5, 3, "R5 held read");

        // R3: end of period, array data returned, toggle stops
        @(negedge clk); busy = 1'b0;
        do_read(13'h0001, 8'h40, 0, "R3 after end");
        do_read(13'h0001, 8'h00, 0, "R3 after end");
        do_read(13'h0155, 8'hFF, 0, "R3 after end");

        // R6: new period clears toggle; first read must show 1
        start_period(8'h00, 13'h0020);
        do_read(13'h0020, 8'h00, 0, "R6 first read");
        check("R6 first toggle", {7'd0, rd_data[DW-2]}, 8'd1);
        do_read(13'h0020, 8'h00, 0, "R5 second read");
        check("R5 second toggle", {7'd0, rd_data[DW-2]}, 8'd0);
        @(negedge clk); busy = 1'b0;

        // R6: read rising in the same cycle as busy rises
        for (int r = 0; r < 2; r++) do_read(13'h0003, 8'h11, 0, "R3 gap");
        @(negedge clk);
        busy = 1'b1; wr_last_data = 8'hFF; wr_last_addr = 13'h1FFF;
        rd_addr = 13'h1FFF; arr_rdata = 8'h81; rd_strobe = 1'b1;
        exp_tgl = 1'b1;
        @(negedge clk);
        check("R6 coincident", rd_data, exp_byte(1'b0));
        check("R6 coincident any", rd_data_any, exp_byte(1'b1));
        rd_strobe = 1'b0;
        // R8: other address, default variant shows array MSB
        do_read(13'h0000, 8'h80, 0, "R8 other addr");
        check("R8 msb from array", {7'd0, rd_data[DW-1]}, 8'd1);
        check("R4 any-addr msb", {7'd0, rd_data_any[DW-1]}, 8'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule